// File: doc/BRIEF.md
# LCD Frame Timing Generator

This block produces the row-scan timing for the common (row) side of a dot-matrix LCD driver. It divides an oscillator clock down to a line clock. It counts line periods into frames, each frame being a block of visible lines followed by a programmable retrace gap. It raises a first-line marker once per frame, and it holds the display blanked for the first few frames after reset. It also exports a frame counter that wraps every three frames, which the output polarity logic downstream uses.

The block can run as a timing master or as a slave. As master it drives its generated line clock, marker and blanking signals onto the shared pads and uses the same signals internally. As slave its generator freezes, its pad drivers turn off, and the internal consumers receive whatever a master device places on the pads. The oscillator clock is a plain digital input. The scan logic that consumes the line clock samples on its falling edge.

Top module: `lcd_frame_timer`

## Requirements
- R1: In master mode the generated line clock toggles on every rising edge of the oscillator clock, giving a period of two oscillator cycles at 50% duty.
- R2: A frame lasts N line-clock periods, with N = V + 6*C. V is 240 when `duty_hi_i` is 1 and 200 when it is 0, and C is the value of `retrace_code_i`. For example, V=240 and C=0 give a frame of 480 oscillator cycles.
- R3: The largest retrace code, 31, adds 186 lines, so with `duty_hi_i`=0 a frame lasts 386 line periods (772 oscillator cycles).
- R4: The first-line marker rises together with the line-clock rising edge that opens a frame. It stays high for exactly one line period (two oscillator cycles), so it is high across the falling edge that ends that period.
- R5: The blanking output (`doff_pad_o`, 1 = display off) is high from reset. It goes low at the oscillator edge that ends the fourth complete frame after reset, and stays low.
- R6: While `master_i` is 0, the generator state is frozen: the line clock, marker, blanking and frame phase outputs hold their values. They resume from that point when `master_i` returns to 1.
- R7: `pad_oe_o` equals `master_i`. The core-side outputs carry the generated signals in master mode and the pad inputs `cl1_pad_i`, `flm_pad_i`, `doff_pad_i` in slave mode, combinationally.
- R8: `duty_hi_i` and `retrace_code_i` are captured at the start of each frame. A change made during a frame first affects the length of the following frame.
- R9: `frame_phase_o` takes the values 0, 1, 2, 0, ... It advances at the edge that ends each frame.
- R10: While `rst_ni` is low, the line clock and marker are 0, the blanking output is 1 and the frame phase is 0. After `rst_ni` rises, the generator starts on the third oscillator rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| master_i | input | 1 | 1 = timing master, 0 = slave (generator frozen) |
| duty_hi_i | input | 1 | 1 = 240 visible lines, 0 = 200 visible lines |
| retrace_code_i | input | 5 | Retrace length in units of 6 lines |
| cl1_pad_i | input | 1 | Line clock received from the pad (slave) |
| flm_pad_i | input | 1 | First-line marker received from the pad (slave) |
| doff_pad_i | input | 1 | Blanking received from the pad (slave) |
| cl1_pad_o | output | 1 | Generated line clock to the pad |
| flm_pad_o | output | 1 | Generated first-line marker to the pad |
| doff_pad_o | output | 1 | Generated blanking to the pad |
| pad_oe_o | output | 1 | Pad output enable for the three timing pads |
| cl1_core_o | output | 1 | Line clock for the internal scan logic |
| flm_core_o | output | 1 | First-line marker for the internal scan logic |
| doff_core_o | output | 1 | Blanking for the internal drivers |
| frame_phase_o | output | 2 | Frame count modulo 3 |

## Verification
Every generated output is registered. Its new value is due right after the oscillator rising edge that follows the input change. The only exception is reset release, where the two-stage synchronizer delays the first active edge to the third rising edge. The core-side outputs in slave mode follow the pads within the same cycle. The bench drives inputs just after the falling edge and compares all outputs at the next falling edge against a reference model that advances at each rising edge. This keeps every comparison one edge after the stimulus that caused it. Frame lengths are also measured between marker rises, for both duty settings, the widest retrace code and a mid-frame configuration change.

// File: rtl/lft_pkg.sv
`timescale 1ns/1ps
package lft_pkg;

  typedef enum logic {
    MODE_SLAVE  = 1'b0,
    MODE_MASTER = 1'b1
  } lft_mode_e;

  typedef struct packed {
    logic cl1;
    logic flm;
    logic doff;
  } lft_sig_t;

endpackage

// File: rtl/lft_line_clock.sv
`timescale 1ns/1ps
module lft_line_clock (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic cl1_o,
  output logic rise_o,
  output logic fall_o
);

  logic cl1_q, cl1_d;

  always_comb begin
    cl1_d = cl1_q;
    if (run_i) cl1_d = ~cl1_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cl1_q <= 1'b0;
    else         cl1_q <= cl1_d;
  end

  assign rise_o = run_i & ~cl1_q;
  assign fall_o = run_i &  cl1_q;
  assign cl1_o  = cl1_q;

  // R1: line clock changes level on every running oscillator edge
  assert_cl1_toggle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |=> (cl1_q != $past(cl1_q)));

endmodule

// File: rtl/lft_line_counter.sv
`timescale 1ns/1ps
module lft_line_counter #(
  parameter int VIS_HI = 240,
  parameter int VIS_LO = 200,
  parameter int STEP   = 6,
  parameter int CODE_W = 5,
  parameter int LINE_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              duty_hi_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              flm_o,
  output logic              wrap_o
);

  logic [LINE_W-1:0] line_q, line_d;
  logic [LINE_W-1:0] len_q, len_d;
  logic [LINE_W-1:0] len_new;
  logic              flm_q, flm_d;
  logic              at_first, at_last;

  assign at_first = (line_q == '0);
  assign at_last  = (line_q == len_q - LINE_W'(1));
  assign len_new  = (duty_hi_i ? LINE_W'(VIS_HI) : LINE_W'(VIS_LO))
                  + LINE_W'(code_i) * LINE_W'(STEP);

  always_comb begin
    line_d = line_q;
    len_d  = len_q;
    flm_d  = flm_q;
    if (rise_i) begin
      flm_d = at_first;
      if (at_first) len_d = len_new;
    end
    if (fall_i) begin
      line_d = at_last ? '0 : line_q + LINE_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= '0;
      len_q  <= LINE_W'(VIS_HI);
      flm_q  <= 1'b0;
    end else begin
      line_q <= line_d;
      len_q  <= len_d;
      flm_q  <= flm_d;
    end
  end

  assign flm_o  = flm_q;
  assign wrap_o = fall_i & at_last;

  // R2: the line index never reaches the frame length
  assert_line_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_q < len_q);

  // R4: marker is only high around the first line period
  assert_flm_window_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flm_q |-> (line_q <= LINE_W'(1)));

  // R8: captured frame length only moves at the frame start
  assert_cfg_frozen_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_q != '0) |=> $stable(len_q));

endmodule

// File: rtl/lft_frame_seq.sv
`timescale 1ns/1ps
module lft_frame_seq #(
  parameter int BLANK_FRAMES = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wrap_i,
  output logic       doff_o,
  output logic [1:0] phase_o
);

  localparam int CNT_W = $clog2(BLANK_FRAMES + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             doff_q, doff_d;
  logic [1:0]       phase_q, phase_d;

  always_comb begin
    cnt_d   = cnt_q;
    doff_d  = doff_q;
    phase_d = phase_q;
    if (wrap_i) begin
      phase_d = (phase_q == 2'd2) ? 2'd0 : phase_q + 2'd1;
      if (doff_q) begin
        cnt_d = cnt_q + CNT_W'(1);
        if (cnt_q == CNT_W'(BLANK_FRAMES - 1)) doff_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      doff_q  <= 1'b1;
      phase_q <= 2'd0;
    end else begin
      cnt_q   <= cnt_d;
      doff_q  <= doff_d;
      phase_q <= phase_d;
    end
  end

  assign doff_o  = doff_q;
  assign phase_o = phase_q;

  // R5: blanking is released only at a frame end
  assert_doff_release_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(doff_q) |-> $past(wrap_i));

  // R5: once released, blanking stays released
  assert_doff_stays_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !doff_q |=> !doff_q);

  // R9: phase stays in its legal range and steps at each frame end
  assert_phase_legal_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q != 2'd3);
  assert_phase_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_i |=> (phase_q != $past(phase_q)));

endmodule

// File: rtl/lcd_frame_timer.sv
`timescale 1ns/1ps
module lcd_frame_timer #(
  parameter int VIS_HI       = 240,
  parameter int VIS_LO       = 200,
  parameter int STEP         = 6,
  parameter int CODE_W       = 5,
  parameter int BLANK_FRAMES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              master_i,
  input  logic              duty_hi_i,
  input  logic [CODE_W-1:0] retrace_code_i,
  input  logic              cl1_pad_i,
  input  logic              flm_pad_i,
  input  logic              doff_pad_i,
  output logic              cl1_pad_o,
  output logic              flm_pad_o,
  output logic              doff_pad_o,
  output logic              pad_oe_o,
  output logic              cl1_core_o,
  output logic              flm_core_o,
  output logic              doff_core_o,
  output logic [1:0]        frame_phase_o
);

  import lft_pkg::*;

  localparam int VIS_MAX = (VIS_HI > VIS_LO) ? VIS_HI : VIS_LO;
  localparam int MAX_LEN = VIS_MAX + STEP * ((1 << CODE_W) - 1);
  localparam int LINE_W  = $clog2(MAX_LEN + 1);

  logic      rst_s1, rst_s2;
  lft_mode_e mode;
  logic      run, rise, fall, wrap;
  lft_sig_t  gen, pad, core;
  logic [1:0] phase;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  assign mode = master_i ? MODE_MASTER : MODE_SLAVE;
  assign run  = (mode == MODE_MASTER);

  lft_line_clock u_clk (
    .clk_i  (clk_i),
    .rst_ni (rst_s2),
    .run_i  (run),
    .cl1_o  (gen.cl1),
    .rise_o (rise),
    .fall_o (fall)
  );

  lft_line_counter #(
    .VIS_HI (VIS_HI),
    .VIS_LO (VIS_LO),
    .STEP   (STEP),
    .CODE_W (CODE_W),
    .LINE_W (LINE_W)
  ) u_lines (
    .clk_i     (clk_i),
    .rst_ni    (rst_s2),
    .rise_i    (rise),
    .fall_i    (fall),
    .duty_hi_i (duty_hi_i),
    .code_i    (retrace_code_i),
    .flm_o     (gen.flm),
    .wrap_o    (wrap)
  );

  lft_frame_seq #(
    .BLANK_FRAMES (BLANK_FRAMES)
  ) u_frames (
    .clk_i   (clk_i),
    .rst_ni  (rst_s2),
    .wrap_i  (wrap),
    .doff_o  (gen.doff),
    .phase_o (phase)
  );

  assign pad  = '{cl1: cl1_pad_i, flm: flm_pad_i, doff: doff_pad_i};
  assign core = run ? gen : pad;

  assign cl1_pad_o     = gen.cl1;
  assign flm_pad_o     = gen.flm;
  assign doff_pad_o    = gen.doff;
  assign pad_oe_o      = run;
  assign cl1_core_o    = core.cl1;
  assign flm_core_o    = core.flm;
  assign doff_core_o   = core.doff;
  assign frame_phase_o = phase;

  // R6: slave mode freezes every generated output
  assert_slave_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_s2)
    !master_i |=> ($stable(gen) && $stable(phase)));

  // R10: nothing is generated while the synchronized reset is held
  assert_reset_quiet_R10: assert property (@(posedge clk_i)
    !rst_s2 |=> (!rst_s2 || (!gen.cl1 && !gen.flm && gen.doff && phase == 2'd0)));

endmodule

// File: tb/tb_lcd_frame_timer.sv
`timescale 1ns/1ps
module tb_lcd_frame_timer;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n, master, duty_hi;
  logic [4:0] code;
  logic       cl1_pi, flm_pi, doff_pi;
  logic       cl1_po, flm_po, doff_po, oe;
  logic       cl1_co, flm_co, doff_co;
  logic [1:0] phase;

  integer checks = 0;
  integer failures = 0;
  bit     done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_frame_timer dut (
    .clk_i (clk), .rst_ni (rst_n), .master_i (master), .duty_hi_i (duty_hi),
    .retrace_code_i (code), .cl1_pad_i (cl1_pi), .flm_pad_i (flm_pi),
    .doff_pad_i (doff_pi), .cl1_pad_o (cl1_po), .flm_pad_o (flm_po),
    .doff_pad_o (doff_po), .pad_oe_o (oe), .cl1_core_o (cl1_co),
    .flm_core_o (flm_co), .doff_core_o (doff_co), .frame_phase_o (phase)
  );

  task automatic chk(input bit ok, input string tag, input integer act, input integer exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  // Reference model: oscillator edges counted within a frame
  integer m_t, m_len, m_frames, m_phase, m_sync;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sync = 0; m_t = -1; m_len = 0; m_frames = 0; m_phase = 0;
    end else begin
      if (m_sync >= 2 && master) begin
        m_t = m_t + 1;
        if (m_len > 0 && m_t == 2 * m_len) m_t = 0;
        if (m_t == 0) m_len = (duty_hi ? 240 : 200) + 6 * code;
        if (m_t == 2 * m_len - 1) begin
          m_frames = m_frames + 1;
          m_phase  = (m_phase + 1) % 3;
        end
      end
      if (m_sync < 2) m_sync = m_sync + 1;
    end
  end

  // Per-cycle comparison and frame interval monitor
  integer cyc = 0;
  integer last_rise = 0;
  integer interval = 0;
  integer rises = 0;
  bit     have_prev = 1'b0;
  bit     prev_flm = 1'b0;

  always @(negedge clk) begin
    bit e_cl1, e_flm, e_doff;
    cyc++;
    e_cl1  = (m_t >= 0) && (m_t % 2 == 0);
    e_flm  = (m_t == 0) || (m_t == 1);
    e_doff = (m_frames < 4);
    if (!done) begin
      chk(cl1_po == e_cl1, master ? "R1 line clock" : "R6 held line clock", cl1_po, e_cl1);
      chk(flm_po == e_flm, master ? "R4 marker" : "R6 held marker", flm_po, e_flm);
      chk(doff_po == e_doff, master ? "R5 blanking" : "R6 held blanking", doff_po, e_doff);
      chk(phase == m_phase[1:0], "R9 frame phase", phase, m_phase);
      chk(oe == master, "R7 output enable", oe, master);
      if (master) begin
        chk(cl1_co == e_cl1 && flm_co == e_flm && doff_co == e_doff, "R7 core follows generator",
            {cl1_co, flm_co, doff_co}, {e_cl1, e_flm, e_doff});
      end else begin
        chk(cl1_co == cl1_pi && flm_co == flm_pi && doff_co == doff_pi, "R7 core follows pads",
            {cl1_co, flm_co, doff_co}, {cl1_pi, flm_pi, doff_pi});
      end
    end
    if (!rst_n || !master) have_prev = 1'b0;
    else if (flm_po && !prev_flm) begin
      if (have_prev) interval = cyc - last_rise;
      last_rise = cyc;
      have_prev = 1'b1;
      rises++;
    end
    prev_flm = flm_po;
  end

  task automatic wait_rises(input integer n);
    integer target;
    target = rises + n;
    while (rises < target) @(negedge clk);
    #1;
  endtask

  task automatic idle(input integer n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    rst_n = 1'b0; master = 1'b1; duty_hi = 1'b1; code = 5'd0;
    cl1_pi = 1'b0; flm_pi = 1'b0; doff_pi = 1'b0;
    idle(4);
    // R10: reset state at the pads
    chk(cl1_po == 1'b0 && flm_po == 1'b0, "R10 reset line clock/marker low", {cl1_po, flm_po}, 0);
    chk(doff_po == 1'b1 && phase == 2'd0, "R10 reset blanking on, phase 0", {doff_po, phase}, 4);
    rst_n = 1'b1;
    idle(2);
    chk(cl1_po == 1'b0, "R10 generator idle during synchronizer", cl1_po, 0);
    idle(1);
    chk(cl1_po == 1'b1 && flm_po == 1'b1, "R10 first active edge", {cl1_po, flm_po}, 3);

    // R2 and R5: 240 visible lines, no retrace
    wait_rises(5);
    chk(interval == 480, "R2 frame length duty high code 0", interval, 480);
    chk(doff_po == 1'b0, "R5 blanking released after four frames", doff_po, 0);

    // R8: change mid-frame, old length still applies to this frame
    idle(100);
    duty_hi = 1'b0; code = 5'd31;
    wait_rises(1);
    chk(interval == 480, "R8 mid-frame change deferred", interval, 480);
    // R3: widest retrace with 200 visible lines
    wait_rises(1);
    chk(interval == 772, "R3 frame length duty low code 31", interval, 772);

    // R6 and R7: slave mode with toggling pads
    idle(37);
    master = 1'b0;
    begin
      logic [4:0] snap;
      snap = {cl1_po, flm_po, doff_po, phase};
      for (int i = 0; i < 60; i++) begin
        cl1_pi = i[0]; flm_pi = i[2]; doff_pi = i[3];
        idle(1);
      end
      chk({cl1_po, flm_po, doff_po, phase} == snap, "R6 outputs frozen in slave",
          {cl1_po, flm_po, doff_po, phase}, snap);
    end
    master = 1'b1; duty_hi = 1'b1; code = 5'd5;
    wait_rises(2);
    chk(interval == 540, "R2 frame length duty high code 5", interval, 540);

    // R10: reset in mid-run
    idle(123);
    rst_n = 1'b0;
    idle(1);
    chk(doff_po == 1'b1 && phase == 2'd0 && cl1_po == 1'b0, "R10 reset mid-run",
        {doff_po, phase, cl1_po}, 8);
    rst_n = 1'b1;
    wait_rises(2);
    chk(interval == 540, "R2 frame length after reset", interval, 540);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired: actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule